// File: doc/BRIEF.md
# Daisy-Chain Command Frame Encoder

This block assembles the 32-bit command word that a host controller shifts down a chain of battery-monitor devices. A requester supplies a 5-bit target device address, a 6-bit register index, an 8-bit data value and a broadcast flag. The block packs these fields into fixed bit positions and adds an 8-bit check byte. It then closes the word with a constant 3-bit trailer and hands the finished word to a downstream serializer over a valid/ready pair.

The check byte uses the CRC-8 generator x^8+x^5+x^3+x^2+x+1 (0x2F), fed MSB-first from a zero start, over the upper 21 bits of the word. The reduction runs in byte steps. The 5-bit top chunk is reduced first. The result is XORed with the middle byte and reduced again. The low byte is then XORed in with no further reduction. Device address 0 selects the chain master and 0x1F selects every part.

The block holds one word at a time. It takes a new request only while it holds nothing. It presents the word one cycle after acceptance and keeps it steady until the consumer takes it.

Top module: `chain_cmd_encoder`

## Requirements
- R1: In every presented word, bits 31..27 carry the device address, bits 26..21 the register index, bits 20..13 the data byte and bit 12 the broadcast flag, and bit 11 is 0.
- R2: Bits 10..3 carry the check byte. It equals the CRC-8 remainder (generator 0x2F, MSB-first, zero start) of word bits 31..19 followed by eight zero bits, XORed with word bits 18..11.
- R3: Bits 2..0 of every presented word are the constant 3'b010.
- R4: A request to device 0x1F with register 0, data 0 and broadcast 0 yields the word 0xF800030A.
- R5: `req_ready` is high exactly when no word is held; a request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- R6: `frm_valid` is high in the cycle right after a request is taken.
- R7: While `frm_valid` is high and `frm_ready` is low, `frm_valid` stays high and `frm_word` does not change.
- R8: After reset, `frm_valid` is low and `req_ready` is high.
- R9: A request presented while a word is held is ignored: the held word is unchanged, and the ignored fields never appear at the output.
- R10: After a clock edge with `frm_valid` and `frm_ready` both high, `frm_valid` is low and `req_ready` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request fields are valid |
| req_ready | output | 1 | Block is empty and takes a request |
| req_dev | input | 5 | Target device address (0 master, 0x1F all) |
| req_reg | input | 6 | Register index |
| req_data | input | 8 | Data value |
| req_bcast | input | 1 | Broadcast flag |
| frm_valid | output | 1 | Finished word is presented |
| frm_ready | input | 1 | Consumer takes the word |
| frm_word | output | 32 | Finished command word |

## Verification
On every cycle, the checker enforces the fixed parts of the word: bit 11 and the trailer. It also recomputes the check byte bit-serially from the presented head bits and checks it against the word. The handshake rules are checked every cycle as well: the one-cycle latency, holding under back-pressure, release after a take, and ready tracking emptiness. What a property cannot show is that the output fields match the request that was accepted and not a later one presented while busy. The bench shows this by comparing each word with one computed from the fields it applied. It also covers the directed all-parts read word, all-zero and all-one fields, and ignored requests during a stall.

// File: rtl/chain_cmd_pkg.sv
package chain_cmd_pkg;

    localparam int DEV_W   = 5;
    localparam int REG_W   = 6;
    localparam int DAT_W   = 8;
    localparam int CRC_W   = 8;
    localparam int TRL_W   = 3;
    localparam int HEAD_W  = DEV_W + REG_W + DAT_W + 2;
    localparam int WORD_W  = HEAD_W + CRC_W + TRL_W;

    localparam logic [CRC_W-1:0] CRC_POLY = 8'h2F;
    localparam logic [TRL_W-1:0] TRAILER  = 3'b010;

    localparam logic [DEV_W-1:0] DEV_MASTER = '0;
    localparam logic [DEV_W-1:0] DEV_ALL    = '1;

    typedef struct packed {
        logic [DEV_W-1:0] dev;
        logic [REG_W-1:0] reg_idx;
        logic [DAT_W-1:0] data;
        logic             bcast;
    } cmd_fields_t;

    typedef struct packed {
        logic [HEAD_W-1:0] head;
        logic [CRC_W-1:0]  check;
        logic [TRL_W-1:0]  tail;
    } cmd_word_t;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_t;

    // One byte through eight shift-and-reduce steps of the generator.
    function automatic logic [CRC_W-1:0] crc_reduce(input logic [CRC_W-1:0] b);
        logic [CRC_W-1:0] r;
        r = b;
        for (int i = 0; i < CRC_W; i++) begin
            if (r[CRC_W-1]) r = {r[CRC_W-2:0], 1'b0} ^ CRC_POLY;
            else            r = {r[CRC_W-2:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/cmd_field_packer.sv
module cmd_field_packer
    import chain_cmd_pkg::*;
(
    input  cmd_fields_t        fields,
    output logic [HEAD_W-1:0]  head
);
    // Head layout: device, register, data, broadcast, then one zero bit.
    always_comb begin
        head = {fields.dev, fields.reg_idx, fields.data, fields.bcast, 1'b0};
    end
endmodule

// File: rtl/cmd_crc8_unit.sv
module cmd_crc8_unit
    import chain_cmd_pkg::*;
#(
    parameter bit BYTE_STEPS = 1'b1
)(
    input  logic [HEAD_W-1:0] head,
    output logic [CRC_W-1:0]  check
);
    localparam int LOW_W = CRC_W;
    localparam int MID_W = CRC_W;
    localparam int TOP_W = HEAD_W - LOW_W - MID_W;

    logic [LOW_W-1:0] low_b;
    logic [MID_W-1:0] mid_b;
    logic [CRC_W-1:0] top_b;

    always_comb begin
        low_b = head[LOW_W-1:0];
        mid_b = head[LOW_W+MID_W-1:LOW_W];
        top_b = CRC_W'(head[HEAD_W-1:LOW_W+MID_W]);
    end

    generate
        if (BYTE_STEPS) begin : g_byte
            // Two byte reductions, low byte folded in unreduced.
            logic [CRC_W-1:0] stage1;
            always_comb begin
                stage1 = crc_reduce(top_b);
                check  = crc_reduce(stage1 ^ mid_b) ^ low_b;
            end
        end else begin : g_bit
            // Unrolled per-bit feedback over the upper bits of the head.
            logic [CRC_W-1:0] acc;
            logic             fb;
            always_comb begin
                acc = '0;
                fb  = 1'b0;
                for (int i = TOP_W + MID_W - 1; i >= 0; i--) begin
                    fb  = acc[CRC_W-1] ^ (i >= MID_W ? top_b[i-MID_W] : mid_b[i]);
                    acc = {acc[CRC_W-2:0], 1'b0};
                    if (fb) acc = acc ^ CRC_POLY;
                end
                check = acc ^ low_b;
            end
        end
    endgenerate
endmodule

// File: rtl/cmd_frame_slot.sv
module cmd_frame_slot
    import chain_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  cmd_word_t         in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output cmd_word_t         out_word
);
    slot_state_t state_q;
    cmd_word_t   word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_EMPTY;
            word_q  <= '0;
        end else begin
            case (state_q)
                SLOT_EMPTY: begin
                    if (in_valid) begin
                        word_q  <= in_word;
                        state_q <= SLOT_FULL;
                    end
                end
                SLOT_FULL: begin
                    if (out_ready) state_q <= SLOT_EMPTY;
                end
                default: state_q <= SLOT_EMPTY;
            endcase
        end
    end

    always_comb begin
        in_ready  = (state_q == SLOT_EMPTY);
        out_valid = (state_q == SLOT_FULL);
        out_word  = word_q;
    end
endmodule

// File: rtl/chain_cmd_encoder.sv
module chain_cmd_encoder
    import chain_cmd_pkg::*;
#(
    parameter bit BYTE_STEPS = 1'b1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [DAT_W-1:0]  req_data,
    input  logic              req_bcast,
    output logic              frm_valid,
    input  logic              frm_ready,
    output logic [WORD_W-1:0] frm_word
);
    cmd_fields_t       fields;
    logic [HEAD_W-1:0] head;
    logic [CRC_W-1:0]  check;
    cmd_word_t         built;
    cmd_word_t         held;

    always_comb begin
        fields.dev     = req_dev;
        fields.reg_idx = req_reg;
        fields.data    = req_data;
        fields.bcast   = req_bcast;
    end

    cmd_field_packer u_pack (
        .fields (fields),
        .head   (head)
    );

    cmd_crc8_unit #(.BYTE_STEPS(BYTE_STEPS)) u_crc (
        .head  (head),
        .check (check)
    );

    always_comb begin
        built.head  = head;
        built.check = check;
        built.tail  = TRAILER;
    end

    cmd_frame_slot u_slot (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_word   (built),
        .out_valid (frm_valid),
        .out_ready (frm_ready),
        .out_word  (held)
    );

    assign frm_word = held;
endmodule

// File: rtl/chain_cmd_encoder_checker.sv
module chain_cmd_encoder_checker
    import chain_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              frm_valid,
    input logic              frm_ready,
    input logic [WORD_W-1:0] frm_word
);
    // Bit-serial remainder, written independently of the byte-step datapath.
    function automatic logic [7:0] serial_check(input logic [20:0] h);
        logic [7:0] r;
        logic       fb;
        r = 8'h00;
        for (int i = 20; i >= 8; i--) begin
            fb = r[7] ^ h[i];
            r  = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h2F;
        end
        return r ^ h[7:0];
    endfunction

    p_bit11_zero_r1: assert property (@(posedge clk) disable iff (rst)
        frm_valid |-> (frm_word[11] == 1'b0));

    p_check_byte_r2: assert property (@(posedge clk) disable iff (rst)
        frm_valid |-> (frm_word[10:3] == serial_check(frm_word[31:11])));

    p_trailer_r3: assert property (@(posedge clk) disable iff (rst)
        frm_valid |-> (frm_word[2:0] == 3'b010));

    p_ready_empty_r5: assert property (@(posedge clk) disable iff (rst)
        req_ready != frm_valid);

    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> frm_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_word)));

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !frm_ready && req_valid) |=> $stable(frm_word));

    p_release_r10: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_ready) |=> (!frm_valid && req_ready));
endmodule

bind chain_cmd_encoder chain_cmd_encoder_checker u_checker (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .frm_valid (frm_valid),
    .frm_ready (frm_ready),
    .frm_word  (frm_word)
);

// File: tb/chain_cmd_encoder_test.sv
`timescale 1ns/1ps
module chain_cmd_encoder_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [4:0]  req_dev;
    logic [5:0]  req_reg;
    logic [7:0]  req_data;
    logic        req_bcast;
    logic        frm_valid;
    logic        frm_ready;
    logic [31:0] frm_word;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    chain_cmd_encoder uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_dev(req_dev), .req_reg(req_reg), .req_data(req_data), .req_bcast(req_bcast),
        .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_word(frm_word)
    );

    function automatic logic [7:0] ref_crc(input logic [20:0] h);
        logic [7:0] r;
        logic       fb;
        r = 8'h00;
        for (int i = 20; i >= 8; i--) begin
            fb = r[7] ^ h[i];
            r  = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h2F;
        end
        return r ^ h[7:0];
    endfunction

    function automatic logic [31:0] ref_word(input logic [4:0] d, input logic [5:0] g,
                                             input logic [7:0] v, input logic b);
        logic [20:0] h;
        h = {d, g, v, b, 1'b0};
        return {h, ref_crc(h), 3'b010};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one request, optionally stall, offer a stray request while busy, then release.
    task automatic send(input logic [4:0] d, input logic [5:0] g, input logic [7:0] v,
                        input logic b, input int stall, input string tag);
        logic [31:0] exp;
        exp = ref_word(d, g, v, b);
        @(negedge clk);
        check("R5 ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_dev = d; req_reg = g; req_data = v; req_bcast = b;
        @(negedge clk);
        check("R6 valid one cycle after accept", {31'd0, frm_valid}, 32'd1);
        check("R5 ready low while held", {31'd0, req_ready}, 32'd0);
        check(tag, frm_word, exp);
        req_dev = ~d; req_reg = ~g; req_data = ~v; req_bcast = ~b;
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check("R7 valid held under stall", {31'd0, frm_valid}, 32'd1);
            check("R9 busy request ignored", frm_word, exp);
        end
        req_valid = 1'b0;
        frm_ready = 1'b1;
        @(negedge clk);
        frm_ready = 1'b0;
        check("R10 valid drops after take", {31'd0, frm_valid}, 32'd0);
        check("R10 ready returns after take", {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; req_valid = 1'b0; frm_ready = 1'b0;
        req_dev = '0; req_reg = '0; req_data = '0; req_bcast = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 valid low after reset", {31'd0, frm_valid}, 32'd0);
        check("R8 ready high after reset", {31'd0, req_ready}, 32'd1);

        // R4: all-parts address, register 0, zero data
        send(5'h1F, 6'h00, 8'h00, 1'b0, 0, "R4 all-parts read word");
        check("R4 constant word", ref_word(5'h1F, 6'h00, 8'h00, 1'b0), 32'hF800030A);
        // R1 master broadcast, all-zero and all-one fields
        send(5'h00, 6'h0E, 8'h5A, 1'b1, 1, "R1 master broadcast word");
        send(5'h00, 6'h00, 8'h00, 1'b0, 2, "R2 all-zero fields");
        send(5'h1F, 6'h3F, 8'hFF, 1'b1, 3, "R3 all-one fields");

        for (int n = 0; n < 300; n++) begin
            send(5'($urandom), 6'($urandom), 8'($urandom), 1'($urandom),
                 int'($urandom_range(0, 3)), "R2 random word");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule